// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front-End

This block is the digital input stage of a two-channel 12-bit converter. A host shifts 16-bit command words into it, most significant bit first, over a three-wire serial link. The link has a serial clock, a data line and an active-low frame select. The block keeps a staging buffer and two channel code registers. Both channels can therefore be loaded in advance and then change together on a single clock edge.

The upper four bits of each word are program bits. Two of them form a register-select code. The other two set the speed flag and the power-down flag, and every complete word carries and refreshes both flags. The lower twelve bits are the data value.

The serial clock also clocks the register stage. Data is sampled on the falling edge. Register updates happen on the rising edge that follows the sixteenth falling-edge sample.

Top module: `dac_cmd_port`

## Requirements
- R1: While `rst_n` is low, `code_a`, `code_b`, the staging buffer, `fast_mode`, `power_down` and `update` are all 0. This means slow mode and normal operation.
- R2: The block samples `sdi` on each falling edge of `sclk` while `frame_n` is low, most significant bit first. Bits 11..0 of a word are the data value. Bits 15..12 are the program bits.
- R3: On each complete word, `fast_mode` takes bit 14 and `power_down` takes bit 13. This holds for every select code, including the reserved one. Between words, both flags hold their values.
- R4: Select code {bit15,bit12} = 00 writes the data value into both `code_b` and the staging buffer. `code_a` is left unchanged.
- R5: Select code 01 writes the data value into the staging buffer only. Neither `code_a` nor `code_b` changes.
- R6: Select code 10 writes the data value into `code_a`. On the same edge, it copies the staging buffer (its value before this word) into `code_b`.
- R7: Select code 11 is reserved. It leaves `code_a`, `code_b` and the staging buffer unchanged.
- R8: The registers selected by a word change on the first rising edge of `sclk` after the sixteenth bit of that word is sampled. At no other time do they change.
- R9: If `frame_n` goes high before 16 bits have been sampled, the partial word is discarded. It changes nothing, and the next frame starts again at bit 15.
- R10: `update` is high for exactly one `sclk` cycle, starting at the update edge of each word with select code 00 or 10. It stays low for select codes 01 and 11.
- R11: While `frame_n` stays low, each further group of 16 bits forms a new word. That word is decoded in the same way as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock: data sampled on the falling edge, registers updated on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| fast_mode | output | 1 | 1 = fast settling mode, 0 = slow mode |
| power_down | output | 1 | 1 = power-down requested |
| update | output | 1 | One-cycle strobe when a channel register is written |

## Verification
The bench loads channel B's staging buffer with one value and then writes channel A. It checks that channel B takes the old buffered value on the same edge. A design that copied after the buffer was overwritten, or on a later edge, would show the wrong code on B.

It sends a buffer-only word and a reserved word and then reads both channels. This catches a design that lets either word leak into an output register. The reserved word is followed by a simultaneous update, which shows whether the reserved word altered the buffer.

A frame is cut short after ten bits and followed by a clean word. A design that kept the bit count across frames would decode a misaligned word. Two words sent in one unbroken frame show that the bit counter wraps rather than stalls.

// File: rtl/dac_cmd_port.sv
module dac_cmd_port #(
  parameter int DW = 12
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          sdi,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          fast_mode,
  output logic          power_down,
  output logic          update
);
  localparam int WW = DW + 4;
  localparam int CW = $clog2(WW);

  logic [WW-1:0] shreg;
  logic [CW-1:0] bitcnt;
  logic          ready;
  logic [DW-1:0] stage;

  wire [1:0]    sel  = {shreg[WW-1], shreg[WW-4]};
  wire [DW-1:0] data = shreg[DW-1:0];

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      ready  <= 1'b0;
    end else if (frame_n) begin
      bitcnt <= '0;
      ready  <= 1'b0;
    end else begin
      shreg  <= {shreg[WW-2:0], sdi};
      bitcnt <= bitcnt + 1'b1;
      ready  <= (bitcnt == CW'(WW - 1));
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      code_a     <= '0;
      code_b     <= '0;
      stage      <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
      update     <= 1'b0;
    end else begin
      update <= 1'b0;
      if (ready) begin
        fast_mode  <= shreg[WW-2];
        power_down <= shreg[WW-3];
        case (sel)
          2'b00: begin
            code_b <= data;
            stage  <= data;
            update <= 1'b1;
          end
          2'b01: stage <= data;
          2'b10: begin
            code_a <= data;
            code_b <= stage;
            update <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_hold_idle_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    !ready |=> $stable(code_a) && $stable(code_b));

  p_flags_hold_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !ready |=> $stable(fast_mode) && $stable(power_down));

  p_strobe_pulse_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    update |=> !update);

  p_a_change_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(code_a) |-> update);

  p_b_change_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(code_b) |-> update);

  p_reserved_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    (ready && sel == 2'b11) |=> !update && $stable(code_a) && $stable(code_b) && $stable(stage));

  p_bufonly_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    (ready && sel == 2'b01) |=> !update && $stable(code_a) && $stable(code_b));
endmodule

// File: tb/test_dac_cmd_port.sv
module test_dac_cmd_port;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic sdi = 1'b0;
  logic [11:0] code_a, code_b;
  logic fast_mode, power_down, update;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [11:0] e_a = '0, e_b = '0, e_buf = '0;
  logic e_fast = 0, e_pd = 0, e_upd = 0;
  logic upd_seen;

  always #2 sclk = ~sclk;

  dac_cmd_port i_dac_cmd_port (
    .sclk(sclk), .rst_n(rst_n), .frame_n(frame_n), .sdi(sdi),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode),
    .power_down(power_down), .update(update)
  );

  function automatic logic [15:0] mk(input logic r1, input logic spd,
                                     input logic pwr, input logic r0,
                                     input logic [11:0] d);
    return {r1, spd, pwr, r0, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] w);
    e_fast = w[14];
    e_pd   = w[13];
    e_upd  = 0;
    case ({w[15], w[12]})
      2'b00: begin e_b = w[11:0]; e_buf = w[11:0]; e_upd = 1; end
      2'b01: e_buf = w[11:0];
      2'b10: begin e_b = e_buf; e_a = w[11:0]; e_upd = 1; end
      default: ;
    endcase
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = w[15 - i];
      @(negedge sclk); #1;
    end
  endtask

  task automatic send(input logic [15:0] w, input bit keep);
    @(posedge sclk); #1;
    frame_n = 1'b0;
    shift_bits(w, 16);
    @(posedge sclk); #1;
    upd_seen = update;
    model(w);
    if (!keep) frame_n = 1'b1;
  endtask

  task automatic chk_all(input string req);
    chk({req, " code_a"}, code_a, e_a);
    chk({req, " code_b"}, code_b, e_b);
    chk({req, " fast"}, fast_mode, e_fast);
    chk({req, " pd"}, power_down, e_pd);
  endtask

  task automatic t_reset;
    chk_all("R1 reset");
    chk("R1 update", update, 0);
  endtask

  task automatic t_load_b;
    send(mk(0, 1, 0, 0, 12'hA5C), 0);
    chk("R4 R8 strobe", upd_seen, 1);
    chk_all("R4 load B");
    @(posedge sclk); #1;
    chk("R10 one cycle", update, 0);
  endtask

  task automatic t_buffer_only;
    send(mk(0, 0, 0, 1, 12'h3E7), 0);
    chk("R5 no strobe", upd_seen, 0);
    chk_all("R5 buffer only");
  endtask

  task automatic t_simul;
    send(mk(1, 1, 0, 0, 12'h801), 0);
    chk("R6 strobe", upd_seen, 1);
    chk("R6 B from buffer", code_b, 12'h3E7);
    chk_all("R6 simultaneous");
  endtask

  task automatic t_reserved;
    send(mk(0, 0, 0, 1, 12'h155), 0);
    send(mk(1, 1, 1, 1, 12'hFFF), 0);
    chk("R7 no strobe", upd_seen, 0);
    chk_all("R7 R3 reserved");
    send(mk(1, 0, 0, 0, 12'h0F0), 0);
    chk("R7 buffer kept", code_b, 12'h155);
    chk_all("R7 after");
  endtask

  task automatic t_flags;
    send(mk(0, 0, 1, 1, 12'h000), 0);
    chk("R3 pd set", power_down, 1);
    chk("R3 slow", fast_mode, 0);
    repeat (5) @(posedge sclk);
    #1;
    chk_all("R3 hold");
  endtask

  task automatic t_partial;
    logic [15:0] junk;
    junk = mk(1, 1, 1, 0, 12'hABC);
    @(posedge sclk); #1;
    frame_n = 1'b0;
    shift_bits(junk, 10);
    frame_n = 1'b1;
    repeat (4) @(posedge sclk);
    #1;
    chk_all("R9 partial ignored");
    chk("R9 no strobe", update, 0);
    send(mk(0, 0, 0, 0, 12'h123), 0);
    chk_all("R9 R2 realigned");
  endtask

  task automatic t_back_to_back;
    send(mk(0, 0, 0, 0, 12'h777), 1);
    chk_all("R11 first");
    frame_n = 1'b0;
    shift_bits(mk(1, 1, 0, 0, 12'h9AB), 16);
    @(posedge sclk); #1;
    upd_seen = update;
    model(mk(1, 1, 0, 0, 12'h9AB));
    frame_n = 1'b1;
    chk("R11 strobe", upd_seen, 1);
    chk_all("R11 second");
  endtask

  initial begin
    repeat (3) @(posedge sclk);
    t_reset;
    #1 rst_n = 1'b1;
    t_reset;
    t_load_b;
    t_buffer_only;
    t_simul;
    t_reserved;
    t_flags;
    t_partial;
    t_back_to_back;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule